// File: doc/BRIEF.md
# Gated Retriggerable One-Shot

This block is a clocked monostable pulse generator. It has three asynchronous control inputs: a falling-edge trigger `trig_n_i`, a rising-edge trigger `trig_p_i`, and an active-low clear `clear_n_i`. Each input first passes through a two-flop synchronizer. Edges are then detected on the synchronized values.

A qualifying edge loads a cycle count from `dur_i` and drives `pulse_o` high for that many clock cycles. A qualifying edge that arrives later in the pulse restarts the full count, so a steady stream of triggers keeps the output high indefinitely. A restart is accepted only once at least 30 percent of the current pulse's programmed length has elapsed since the previous accepted trigger. Edges that arrive sooner are dropped.

Clear overrides everything. While it is low the output stays low. Releasing it fires a pulse if the other two inputs are already in their gated-on state. `pulse_n_o` is always the complement of `pulse_o`. Both outputs power up idle without any reset pulse, and a synchronous active-high reset also returns them to idle.

Top module: `gated_oneshot`

## Requirements
- R1: With `clear_n_i` high and `trig_n_i` low, a rise of `trig_p_i` fires a pulse. `pulse_o` goes high on the third rising clock edge after the input change.
- R2: With `clear_n_i` and `trig_p_i` high, a fall of `trig_n_i` fires a pulse with the same three-edge latency.
- R3: With `trig_n_i` low and `trig_p_i` high, a rise of `clear_n_i` fires a pulse with the same latency.
- R4: While the synchronized clear is low, `pulse_o` is low. A pulse in progress ends on the third edge after `clear_n_i` falls, and trigger edges during clear are ignored.
- R5: After the last accepted trigger, `pulse_o` stays high for exactly N clock cycles, where N is the value of `dur_i` captured at that trigger.
- R6: A qualifying edge during a pulse, seen at least ceil(0.30 × N) cycles after the previous accepted trigger, restarts the full N-cycle count from itself.
- R7: A qualifying edge during a pulse, seen fewer than ceil(0.30 × N) cycles after the previous accepted trigger, is ignored and the pulse ends on its original schedule.
- R8: No pulse starts from a `trig_p_i` rise while `trig_n_i` is high, nor from a `trig_n_i` fall while `trig_p_i` is low.
- R9: A change of `dur_i` during a pulse does not alter the length of that pulse.
- R10: A value of zero on `dur_i` yields a one-cycle pulse.
- R11: `pulse_n_o` equals the inverse of `pulse_o` in every cycle.
- R12: At power-up and after reset, `pulse_o` is low and `pulse_n_o` is high. A reset asserted during a pulse ends it on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| trig_n_i | input | 1 | Trigger fired by a falling edge; its low level gates the rising trigger |
| trig_p_i | input | 1 | Trigger fired by a rising edge; its high level gates the falling trigger |
| clear_n_i | input | 1 | Active-low clear; its release can fire a pulse |
| dur_i | input | DUR_W | Pulse length in clock cycles, captured at each accepted trigger |
| pulse_o | output | 1 | One-shot output, active high |
| pulse_n_o | output | 1 | Complement of `pulse_o` |

## Verification
The bench measures where each pulse starts and ends in absolute cycles. An off-by-one in the synchronizer, the edge detector or the down-counter therefore shows up as a pulse that is shifted or one cycle too long or short.

Two retrigger scenarios are placed one cycle apart, on either side of the 30 percent guard. A wrong comparison either stretches a pulse that should have ended or ignores a valid restart.

Clear is tested in three ways: cutting a pulse short, blocking trigger edges while it is low, and firing a pulse on release. A design that gated only some paths would produce a stray pulse.

Other tests change `dur_i` in the middle of a pulse and program a zero length. These expose a counter that reads the live input instead of the captured value, and one that wraps to a very long pulse.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // Synchronized view of the three control inputs.
  typedef struct packed {
    logic trig_n;   // falling-edge trigger, low level enables the rising one
    logic trig_p;   // rising-edge trigger, high level enables the falling one
    logic clear_n;  // active-low override
  } ctl_in_t;

  // Idle levels: nothing armed, clear released.
  localparam ctl_in_t CTL_IDLE = '{trig_n: 1'b1, trig_p: 1'b0, clear_n: 1'b1};

  // Minimum retrigger spacing: ceil(dur * pct / 100).
  function automatic int unsigned guard_of(input int unsigned dur, input int unsigned pct);
    return (dur * pct + 99) / 100;
  endfunction

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int          W      = 3,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Two-flop chain per bit. The flops are deliberately not reset, and
  // they power up at the idle level.
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1 = INIT[i];
    logic s2 = INIT[i];
    always_ff @(posedge clk) begin
      s1 <= d[i];
      s2 <= s1;
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/oneshot_edge.sv
module oneshot_edge
  import oneshot_pkg::*;
(
  input  logic    clk,
  input  ctl_in_t cur,
  output logic    fire
);
  ctl_in_t prev = CTL_IDLE;

  // prev always tracks cur, so inputs held steady through reset leave no edge.
  always_ff @(posedge clk) prev <= cur;

  logic p_rise, n_fall, c_rise, gated_on;

  assign gated_on = ~cur.trig_n & cur.trig_p;
  assign p_rise   = cur.trig_p & ~prev.trig_p & ~cur.trig_n;
  assign n_fall   = ~cur.trig_n & prev.trig_n & cur.trig_p;
  assign c_rise   = cur.clear_n & ~prev.clear_n & gated_on;

  assign fire = cur.clear_n & (p_rise | n_fall | c_rise);
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import oneshot_pkg::*;
#(
  parameter int DUR_W     = 16,
  parameter int GUARD_PCT = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             clear_n,
  input  logic [DUR_W-1:0] dur,
  output logic             accept,
  output logic             pulse,
  output logic             pulse_n
);
  localparam logic [DUR_W-1:0] ONE  = DUR_W'(1);
  localparam logic [DUR_W-1:0] VMAX = '1;

  logic [DUR_W-1:0] cnt_r   = '0;
  logic [DUR_W-1:0] age_r   = '0;
  logic [DUR_W-1:0] guard_r = '0;
  logic             pulse_r   = 1'b0;
  logic             pulse_n_r = 1'b1;

  logic [DUR_W-1:0] dur_eff, guard_new;

  assign dur_eff   = (dur == '0) ? ONE : dur;
  assign guard_new = DUR_W'(guard_of(32'(dur_eff), GUARD_PCT));
  assign accept    = fire & clear_n & (~pulse_r | (age_r >= guard_r));

  always_ff @(posedge clk) begin
    if (rst || !clear_n) begin
      pulse_r   <= 1'b0;
      pulse_n_r <= 1'b1;
      cnt_r     <= '0;
      age_r     <= '0;
    end else if (accept) begin
      pulse_r   <= 1'b1;
      pulse_n_r <= 1'b0;
      cnt_r     <= dur_eff - ONE;
      guard_r   <= guard_new;
      age_r     <= ONE;
    end else if (pulse_r) begin
      if (age_r != VMAX) age_r <= age_r + ONE;
      if (cnt_r == '0) begin
        pulse_r   <= 1'b0;
        pulse_n_r <= 1'b1;
      end else begin
        cnt_r <= cnt_r - ONE;
      end
    end
  end

  assign pulse   = pulse_r;
  assign pulse_n = pulse_n_r;
endmodule

// File: rtl/gated_oneshot.sv
module gated_oneshot
  import oneshot_pkg::*;
#(
  parameter int DUR_W     = 16,
  parameter int GUARD_PCT = 30
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             trig_n_i,
  input  logic             trig_p_i,
  input  logic             clear_n_i,
  input  logic [DUR_W-1:0] dur_i,
  output logic             pulse_o,
  output logic             pulse_n_o
);
  localparam int NCTL = $bits(ctl_in_t);

  ctl_in_t raw_in, sync_in;
  logic    fire, accept, clear_s;

  assign raw_in = '{trig_n: trig_n_i, trig_p: trig_p_i, clear_n: clear_n_i};

  oneshot_sync #(.W(NCTL), .INIT(CTL_IDLE)) sync_i (
    .clk (clk_i),
    .d   (raw_in),
    .q   (sync_in)
  );

  oneshot_edge edge_i (
    .clk  (clk_i),
    .cur  (sync_in),
    .fire (fire)
  );

  assign clear_s = sync_in.clear_n;

  oneshot_timer #(.DUR_W(DUR_W), .GUARD_PCT(GUARD_PCT)) timer_i (
    .clk     (clk_i),
    .rst     (rst_i),
    .fire    (fire),
    .clear_n (clear_s),
    .dur     (dur_i),
    .accept  (accept),
    .pulse   (pulse_o),
    .pulse_n (pulse_n_o)
  );
endmodule

// File: rtl/gated_oneshot_chk.sv
module gated_oneshot_chk (
  input logic clk,
  input logic rst,
  input logic clear_s,
  input logic accept,
  input logic pulse,
  input logic pulse_n
);
  // R11
  qn_compl_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_n == ~pulse);

  // R4
  clear_forces_low_chk: assert property (@(posedge clk) disable iff (rst)
    !clear_s |=> !pulse);

  // R1
  rise_needs_accept_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse) |-> $past(accept));

  // R6
  accept_sets_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> pulse);
endmodule

bind gated_oneshot gated_oneshot_chk chk_i (
  .clk     (clk_i),
  .rst     (rst_i),
  .clear_s (clear_s),
  .accept  (accept),
  .pulse   (pulse_o),
  .pulse_n (pulse_n_o)
);

// File: tb/gated_oneshot_tb_top.sv
`timescale 1ns/1ps
module gated_oneshot_tb_top;
  localparam int DUR_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_n = 1'b1, b_p = 1'b0, clr_n = 1'b1;
  logic [DUR_W-1:0] dur = '0;
  logic q, qn;

  int ncyc = 0, total = 0, bad = 0, mism = 0;
  int rise_at = -1, fall_at = -1;
  logic q_prev = 1'b0;

  always #2 clk = ~clk;

  gated_oneshot #(.DUR_W(DUR_W)) dut_i (
    .clk_i(clk), .rst_i(rst), .trig_n_i(a_n), .trig_p_i(b_p),
    .clear_n_i(clr_n), .dur_i(dur), .pulse_o(q), .pulse_n_o(qn)
  );

  always @(posedge clk) ncyc <= ncyc + 1;

  always @(negedge clk) begin
    if (qn !== ~q) mism++;
    if (q && !q_prev) rise_at = ncyc;
    if (!q && q_prev) fall_at = ncyc;
    q_prev = q;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    a_n = 1'b1; b_p = 1'b0; clr_n = 1'b1;
    cyc(6);
  endtask

  task automatic t_reset_state();
    cyc(5);
    check(q == 1'b0 && qn == 1'b1, "R12 reset state", {q, qn}, 2'b01);
    rst = 1'b0;
    cyc(3);
    check(q == 1'b0, "R12 idle after reset", q, 0);
  endtask

  task automatic t_b_rise();
    int c0;
    idle();
    c0 = ncyc; dur = 5; a_n = 1'b0; b_p = 1'b1;
    cyc(14);
    check(rise_at == c0 + 3, "R1 rise latency", rise_at - c0, 3);
    check(fall_at - rise_at == 5, "R5 width", fall_at - rise_at, 5);
  endtask

  task automatic t_a_fall();
    int c0;
    idle();
    b_p = 1'b1; cyc(4);
    c0 = ncyc; dur = 7; a_n = 1'b0;
    cyc(16);
    check(rise_at == c0 + 3, "R2 rise latency", rise_at - c0, 3);
    check(fall_at - rise_at == 7, "R5 width", fall_at - rise_at, 7);
  endtask

  task automatic t_clear_release();
    int c0;
    idle();
    dur = 6; clr_n = 1'b0; cyc(4);
    a_n = 1'b0; b_p = 1'b1; cyc(6);
    check(q == 1'b0, "R4 edges ignored in clear", q, 0);
    c0 = ncyc; clr_n = 1'b1;
    cyc(15);
    check(rise_at == c0 + 3, "R3 rise latency", rise_at - c0, 3);
    check(fall_at - rise_at == 6, "R5 width", fall_at - rise_at, 6);
  endtask

  task automatic t_clear_cut();
    int c0, c1, r0;
    idle();
    c0 = ncyc; dur = 20; a_n = 1'b0; b_p = 1'b1;
    cyc(8);
    c1 = ncyc; clr_n = 1'b0;
    cyc(6);
    check(fall_at == c1 + 3, "R4 clear cut", fall_at - c1, 3);
    check(rise_at == c0 + 3, "R1 rise before cut", rise_at - c0, 3);
    r0 = rise_at;
    b_p = 1'b0; cyc(2); b_p = 1'b1; cyc(6);
    check(q == 1'b0 && rise_at == r0, "R4 trigger during clear", q, 0);
    a_n = 1'b1; b_p = 1'b0; cyc(3);
    clr_n = 1'b1; cyc(8);
    check(q == 1'b0 && rise_at == r0, "R8 release with A high", q, 0);
  endtask

  task automatic t_gating();
    int r0;
    idle();
    dur = 4; r0 = rise_at;
    b_p = 1'b1; cyc(8);
    check(q == 1'b0 && rise_at == r0, "R8 B rise with A high", q, 0);
    b_p = 1'b0; cyc(4);
    a_n = 1'b0; cyc(8);
    check(q == 1'b0 && rise_at == r0, "R8 A fall with B low", q, 0);
  endtask

  task automatic t_retrig_ok();
    int c0;
    idle();
    a_n = 1'b0; cyc(3);
    c0 = ncyc; dur = 10; b_p = 1'b1;
    cyc(1); b_p = 1'b0;
    cyc(2); b_p = 1'b1;
    cyc(22);
    check(rise_at == c0 + 3, "R6 first rise", rise_at - c0, 3);
    check(fall_at == c0 + 16, "R6 restarted end", fall_at - c0, 16);
  endtask

  task automatic t_retrig_early();
    int c0;
    idle();
    a_n = 1'b0; cyc(3);
    c0 = ncyc; dur = 10; b_p = 1'b1;
    cyc(1); b_p = 1'b0;
    cyc(1); b_p = 1'b1;
    cyc(22);
    check(fall_at == c0 + 13, "R7 early retrigger ignored", fall_at - c0, 13);
  endtask

  task automatic t_latch();
    idle();
    dur = 12; a_n = 1'b0; b_p = 1'b1;
    cyc(5); dur = 3;
    cyc(18);
    check(fall_at - rise_at == 12, "R9 captured length", fall_at - rise_at, 12);
  endtask

  task automatic t_zero();
    int c0;
    idle();
    c0 = ncyc; dur = 0; a_n = 1'b0; b_p = 1'b1;
    cyc(8);
    check(rise_at == c0 + 3, "R10 zero rise", rise_at - c0, 3);
    check(fall_at - rise_at == 1, "R10 zero width", fall_at - rise_at, 1);
  endtask

  task automatic t_reset_mid();
    int c1;
    idle();
    dur = 30; a_n = 1'b0; b_p = 1'b1;
    cyc(6);
    c1 = ncyc; rst = 1'b1;
    cyc(2);
    check(fall_at == c1 + 1, "R12 reset ends pulse", fall_at - c1, 1);
    check(q == 1'b0 && qn == 1'b1, "R12 outputs in reset", {q, qn}, 2'b01);
    rst = 1'b0; cyc(4);
  endtask

  initial begin
    t_reset_state();
    t_b_rise();
    t_a_fall();
    t_clear_release();
    t_clear_cut();
    t_gating();
    t_retrig_ok();
    t_retrig_early();
    t_latch();
    t_zero();
    t_reset_mid();
    idle();
    check(mism == 0, "R11 complement", mism, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule